// File: doc/BRIEF.md
# Predicated Execution Gate with Status Flags

This block sits next to the execute stage of a pipeline and decides, for every issued instruction, whether that instruction is allowed to change machine state. It keeps the four status flags: negative, zero, carry and overflow. It tests each instruction's 4-bit predicate field against those flags, and it masks the register-file write and the flag write of any instruction whose predicate is false.

The predicate is evaluated combinationally, in the issue cycle, against the flags as they stood before that instruction. An instruction that passes and carries the set-flags bit loads the ALU's new flags at the end of its cycle, so the instruction issued in the following cycle already sees them. An ordinary data operation without the set-flags bit never disturbs the flags. Opcode decoding happens elsewhere; this block only sees the predicate, the set-flags bit, the ALU flags and a wanted-write strobe.

Top module: `cex_ctrl`

## Requirements
- R1: After synchronous reset, flags_o reads 4'b0000 and pass_o is low while issue_i is low. Flag bit order on alu_flags_i and flags_o is [3]=N, [2]=Z, [1]=C, [0]=V.
- R2: Predicate 4'h0 passes when Z is set, and predicate 4'h1 passes when Z is clear.
- R3: Single-flag predicates pass as follows: 4'h2 on C set, 4'h3 on C clear, 4'h4 on N set, 4'h5 on N clear, 4'h6 on V set, 4'h7 on V clear.
- R4: Unsigned compound predicates: 4'h8 passes when C is set and Z is clear, and 4'h9 passes when C is clear or Z is set.
- R5: Signed predicates: 4'hA passes when N equals V, 4'hB when N differs from V, 4'hC when Z is clear and N equals V, and 4'hD when Z is set or N differs from V.
- R6: Predicate 4'hE passes for every flag value. Predicate 4'hF never passes, so the instruction has no effect.
- R7: wr_en_o is high exactly when issue_i is high, the predicate passes and want_wr_i is high, all in the same cycle.
- R8: When issue_i is high, the predicate passes and set_flags_i is high, flags_o equals that cycle's alu_flags_i from the next cycle on, and the next instruction's predicate is judged against the new value.
- R9: flags_o keeps its value across a cycle in which set_flags_i is low, or the predicate fails, or issue_i is low.
- R10: While issue_i is low, pass_o and wr_en_o are low whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An instruction is issued this cycle |
| cond_i | input | 4 | Predicate field of the issued instruction |
| set_flags_i | input | 1 | Instruction asks to write the flags |
| alu_flags_i | input | 4 | New N,Z,C,V from the ALU |
| want_wr_i | input | 1 | Instruction wants to write the register file |
| pass_o | output | 1 | Predicate true for the issued instruction |
| wr_en_o | output | 1 | Gated register-file write enable |
| flags_o | output | 4 | Current N,Z,C,V |

## Verification
Every one of the sixteen predicates is tried against all sixteen flag values. The flags are loaded through the block's own set-flags path, so each predicate is shown to depend on exactly its flags and on nothing else. The write gate is tried in every combination of issue, pass and wanted write. The flag register is tried with back-to-back instructions, where the second instruction's predicate shows whether the first one's update became visible one cycle later. It is also tried with a missing set-flags bit, a failing predicate and no issue, each of which must leave the flags as they were.

// File: rtl/cex_pkg.sv
package cex_pkg;

    localparam int COND_W    = 4;
    localparam int FLAG_W    = 4;
    localparam int NUM_CODES = 1 << COND_W;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cex_flags_t;

    typedef enum logic [COND_W-1:0] {
        PR_ZSET   = 4'h0,
        PR_ZCLR   = 4'h1,
        PR_CSET   = 4'h2,
        PR_CCLR   = 4'h3,
        PR_NSET   = 4'h4,
        PR_NCLR   = 4'h5,
        PR_VSET   = 4'h6,
        PR_VCLR   = 4'h7,
        PR_UABOVE = 4'h8,
        PR_UNOTAB = 4'h9,
        PR_SGE    = 4'hA,
        PR_SLT    = 4'hB,
        PR_SGT    = 4'hC,
        PR_SLE    = 4'hD,
        PR_ALWAYS = 4'hE,
        PR_NEVER  = 4'hF
    } cex_pred_e;

    typedef struct packed {
        logic reg_we;
        logic flag_we;
    } cex_gate_t;

    function automatic logic pred_holds(cex_pred_e p, cex_flags_t f);
        logic nv_eq;
        nv_eq = (f.n == f.v);
        unique case (p)
            PR_ZSET:   return f.z;
            PR_ZCLR:   return !f.z;
            PR_CSET:   return f.c;
            PR_CCLR:   return !f.c;
            PR_NSET:   return f.n;
            PR_NCLR:   return !f.n;
            PR_VSET:   return f.v;
            PR_VCLR:   return !f.v;
            PR_UABOVE: return f.c && !f.z;
            PR_UNOTAB: return !f.c || f.z;
            PR_SGE:    return nv_eq;
            PR_SLT:    return !nv_eq;
            PR_SGT:    return !f.z && nv_eq;
            PR_SLE:    return f.z || !nv_eq;
            PR_ALWAYS: return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cex_pred_eval.sv
module cex_pred_eval
    import cex_pkg::*;
(
    input  cex_flags_t           flags,
    input  logic [COND_W-1:0]    code,
    output logic                 holds
);
    logic [NUM_CODES-1:0] hit;

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        localparam logic [COND_W-1:0] CI = COND_W'(i);
        assign hit[i] = pred_holds(cex_pred_e'(CI), flags);
    end

    assign holds = hit[code];

    always_comb begin
        if (code == PR_ALWAYS) assert_always_R6: assert (holds);
        if (code == PR_NEVER)  assert_never_R6:  assert (!holds);
    end
endmodule

// File: rtl/cex_gate.sv
module cex_gate
    import cex_pkg::*;
(
    input  logic      issue,
    input  logic      holds,
    input  logic      want_wr,
    input  logic      set_flags,
    output logic      pass,
    output cex_gate_t gate
);
    assign pass         = issue && holds;
    assign gate.reg_we  = pass && want_wr;
    assign gate.flag_we = pass && set_flags;
endmodule

// File: rtl/cex_flag_reg.sv
module cex_flag_reg
    import cex_pkg::*;
#(
    parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  cex_flags_t d,
    output cex_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= cex_flags_t'(RESET_FLAGS);
        else if (we) q <= d;
    end

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)));
    assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/cex_ctrl.sv
module cex_ctrl
    import cex_pkg::*;
#(
    parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic              set_flags_i,
    input  logic [FLAG_W-1:0] alu_flags_i,
    input  logic              want_wr_i,
    output logic              pass_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);
    cex_flags_t cur_flags;
    logic       holds;
    cex_gate_t  gate;

    cex_pred_eval u_eval (
        .flags (cur_flags),
        .code  (cond_i),
        .holds (holds)
    );

    cex_gate u_gate (
        .issue     (issue_i),
        .holds     (holds),
        .want_wr   (want_wr_i),
        .set_flags (set_flags_i),
        .pass      (pass_o),
        .gate      (gate)
    );

    cex_flag_reg #(.RESET_FLAGS(RESET_FLAGS)) u_flags (
        .clk (clk),
        .rst (rst),
        .we  (gate.flag_we),
        .d   (cex_flags_t'(alu_flags_i)),
        .q   (cur_flags)
    );

    assign wr_en_o = gate.reg_we;
    assign flags_o = cur_flags;

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !issue_i |-> (!pass_o && !wr_en_o));
    assert_fail_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !pass_o) |-> !wr_en_o);
    assert_fail_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !pass_o) |=> $stable(flags_o));
    assert_update_R8: assert property (@(posedge clk) disable iff (rst)
        (pass_o && set_flags_i) |=> (flags_o == $past(alu_flags_i)));
endmodule

// File: tb/sim_cex_ctrl.sv
`timescale 1ns/1ps
module sim_cex_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       issue_i, set_flags_i, want_wr_i;
    logic [3:0] cond_i, alu_flags_i;
    logic       pass_o, wr_en_o;
    logic [3:0] flags_o;
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    cex_ctrl u0 (
        .clk(clk), .rst(rst), .issue_i(issue_i), .cond_i(cond_i),
        .set_flags_i(set_flags_i), .alu_flags_i(alu_flags_i),
        .want_wr_i(want_wr_i), .pass_o(pass_o), .wr_en_o(wr_en_o),
        .flags_o(flags_o)
    );

    // Expected predicate outcome; flags f = {N,Z,C,V}
    function automatic logic model(logic [3:0] c, logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy & !z;
            4'h9: return !cy | z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z & (n == v);
            4'hD: return z | (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        issue_i = 0; set_flags_i = 0; want_wr_i = 0; cond_i = 4'hE; alu_flags_i = 4'h0;
    endtask

    // Load flags through an always-pass, set-flags instruction
    task automatic load(logic [3:0] f);
        @(negedge clk);
        issue_i = 1; cond_i = 4'hE; set_flags_i = 1; alu_flags_i = f; want_wr_i = 0;
        @(negedge clk);
        idle();
    endtask

    task automatic sweep(string req, logic [3:0] lo, logic [3:0] hi);
        for (int f = 0; f < 16; f++) begin
            load(4'(f));
            for (int c = int'(lo); c <= int'(hi); c++) begin
                issue_i = 1; cond_i = 4'(c); want_wr_i = 1;
                #1;
                chk(req, {3'b0, pass_o}, {3'b0, model(4'(c), 4'(f))});
            end
            idle();
        end
    endtask

    task automatic t_reset();
        rst = 1; idle();
        repeat (2) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 flags", flags_o, 4'h0);
        chk("R1 pass", {3'b0, pass_o}, 4'h0);
    endtask

    task automatic t_write_gate();
        load(4'b0100);            // Z set
        for (int k = 0; k < 8; k++) begin
            logic is, ok, ww;
            {is, ok, ww} = 3'(k);
            issue_i = is; cond_i = ok ? 4'h0 : 4'h1; want_wr_i = ww;
            #1;
            chk("R7 wr_en", {3'b0, wr_en_o}, {3'b0, is & ok & ww});
        end
        idle();
    endtask

    task automatic t_update();
        load(4'b0000);
        @(negedge clk);
        issue_i = 1; cond_i = 4'hE; set_flags_i = 1; alu_flags_i = 4'b0100; want_wr_i = 1;
        #1 chk("R8 old flags seen", {3'b0, model(4'h0, flags_o)}, 4'h0);
        @(negedge clk);
        issue_i = 1; cond_i = 4'h0; set_flags_i = 0; alu_flags_i = 4'h0;
        #1;
        chk("R8 new flags", flags_o, 4'b0100);
        chk("R8 next instr sees", {3'b0, pass_o}, 4'h1);
        idle();
    endtask

    task automatic t_hold();
        load(4'b1010);
        @(negedge clk);
        issue_i = 1; cond_i = 4'h0; set_flags_i = 1; alu_flags_i = 4'b0101;
        @(negedge clk);
        chk("R9 failed pred", flags_o, 4'b1010);
        issue_i = 1; cond_i = 4'hE; set_flags_i = 0; alu_flags_i = 4'b0101;
        @(negedge clk);
        chk("R9 no S bit", flags_o, 4'b1010);
        issue_i = 0; cond_i = 4'hE; set_flags_i = 1; alu_flags_i = 4'b0101;
        @(negedge clk);
        chk("R9 no issue", flags_o, 4'b1010);
        issue_i = 1; cond_i = 4'hF; set_flags_i = 1; want_wr_i = 1;
        #1 chk("R6 never no write", {3'b0, wr_en_o}, 4'h0);
        @(negedge clk);
        chk("R6 never no flags", flags_o, 4'b1010);
        idle();
    endtask

    task automatic t_no_issue();
        for (int c = 0; c < 16; c++) begin
            issue_i = 0; cond_i = 4'(c); want_wr_i = 1; set_flags_i = 1;
            #1;
            chk("R10 pass", {3'b0, pass_o}, 4'h0);
            chk("R10 wr_en", {3'b0, wr_en_o}, 4'h0);
        end
        idle();
    endtask

    initial begin
        t_reset();
        sweep("R2", 4'h0, 4'h1);
        sweep("R3", 4'h2, 4'h7);
        sweep("R4", 4'h8, 4'h9);
        sweep("R5", 4'hA, 4'hD);
        sweep("R6", 4'hE, 4'hF);
        t_write_gate();
        t_update();
        t_hold();
        t_no_issue();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule